// File: doc/BRIEF.md
# Sparsified Priority Readout Channel

This block is the readout engine for one group of pixels. Each pixel reports a flag that says it still holds nonzero counts, together with a small count value. The engine always picks the pixel with the highest address whose flag is set. It sends that pixel a one-cycle readout strobe and samples the count the pixel hands over. It then sends the pixel address and the count as one serial word on a single data line, with a frame signal that marks the word.

The same pixel is strobed again for as long as its flag stays set. The engine moves to a lower address only once that flag has cleared. A strobe that returns a zero count produces no word, and the engine goes straight on. A channel-level OR output shows whether any pixel in the group still holds data. Sixteen copies of this channel run side by side, each with its own serial line.

Top module: `sro_channel`

## Requirements
- R1: After reset, every strobe is low, `frame_o` is low and `sdata_o` is low.
- R2: Among the pixels whose flag is set, the pixel with the highest address is served first. Words leave in descending address order, provided no flag rises during the scan.
- R3: Each strobe is one-hot, lasts exactly one cycle and goes to the selected pixel.
- R4: While the selected pixel's flag stays set, that same pixel is strobed again. A lower address is served only after the flag clears.
- R5: A word is 14 bits sent MSB first: bit 13 is a start bit of 1, bits 12..5 hold the 8-bit pixel address and bits 4..0 hold the 5-bit count.
- R6: `frame_o` is high for exactly 14 consecutive cycles per word, one for each bit.
- R7: No strobe is issued while a word is being shifted out. The next strobe follows only after the last bit.
- R8: The count is sampled in the cycle after the strobe. A zero count produces no word and no frame, and the scan continues.
- R9: `hit_or_o` is high exactly while at least one pixel flag is set.
- R10: `sdata_o` is low whenever `frame_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nz_i | input | N_PIX | Per-pixel flag, set while the pixel holds nonzero counts |
| cnt_i | input | N_PIX*CNT_W | Per-pixel count handed over after a strobe; pixel p occupies bits p*CNT_W upward |
| strobe_o | output | N_PIX | Per-pixel readout strobe |
| sdata_o | output | 1 | Serial word data, MSB first |
| frame_o | output | 1 | High while a word is on `sdata_o` |
| hit_or_o | output | 1 | OR of all pixel flags |

## Verification
The bench builds the channel with its default 256 pixels and 5-bit counts. This puts both address extremes, 0 and 255, and the full-scale count of 31 within reach, and the start bit and field positions are exercised at full width. A behavioural pixel model in the bench holds a queue of counts for each pixel. Zero entries in a queue exercise suppressed reads, and several entries on one pixel exercise repeated strobing. Scattered multi-pixel loads check the descending order.

// File: rtl/sro_pkg.sv
package sro_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STB  = 2'd1,
    ST_CAP  = 2'd2,
    ST_SEND = 2'd3
  } sro_state_e;
endpackage

// File: rtl/sro_prio_enc.sv
module sro_prio_enc #(
  parameter int N      = 256,
  parameter int ADDR_W = $clog2(N)
) (
  input  logic [N-1:0]      req_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              any_o
);
  // later (higher) indices overwrite earlier ones
  always_comb begin
    addr_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) addr_o = ADDR_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/sro_pix_port.sv
module sro_pix_port #(
  parameter int N      = 256,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = $clog2(N)
) (
  input  logic [ADDR_W-1:0]  sel_i,
  input  logic               stb_en_i,
  input  logic [N*CNT_W-1:0] cnt_i,
  output logic [N-1:0]       strobe_o,
  output logic [CNT_W-1:0]   cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_stb
    assign strobe_o[g] = stb_en_i && (sel_i == ADDR_W'(g));
  end

  assign cnt_o = cnt_i[sel_i*CNT_W +: CNT_W];
endmodule

// File: rtl/sro_word_ser.sv
module sro_word_ser #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 5,
  localparam int WORD_W = 1 + ADDR_W + CNT_W,
  localparam int BC_W   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              sdata_o,
  output logic              frame_o,
  output logic              done_o
);
  logic [WORD_W-1:0] sh_q;
  logic [BC_W-1:0]   bc_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bc_q   <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= {1'b1, addr_i, cnt_i};
      bc_q   <= BC_W'(WORD_W - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sh_q <= sh_q << 1;
      if (bc_q == '0) busy_q <= 1'b0;
      else            bc_q   <= bc_q - 1'b1;
    end
  end

  assign frame_o = busy_q;
  assign sdata_o = busy_q & sh_q[WORD_W-1];
  assign done_o  = busy_q && (bc_q == '0);
endmodule

// File: rtl/sro_channel.sv
module sro_channel
  import sro_pkg::*;
#(
  parameter int N_PIX = 256,
  parameter int CNT_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_PIX-1:0]       nz_i,
  input  logic [N_PIX*CNT_W-1:0] cnt_i,
  output logic [N_PIX-1:0]       strobe_o,
  output logic                   sdata_o,
  output logic                   frame_o,
  output logic                   hit_or_o
);
  localparam int ADDR_W = $clog2(N_PIX);

  sro_state_e        st_q, st_d;
  logic [ADDR_W-1:0] sel_q, enc_addr;
  logic              enc_any;
  logic [CNT_W-1:0]  cnt_sel;
  logic              ser_load, ser_done;

  sro_prio_enc #(.N(N_PIX), .ADDR_W(ADDR_W)) u_enc (
    .req_i (nz_i),
    .addr_o(enc_addr),
    .any_o (enc_any)
  );

  sro_pix_port #(.N(N_PIX), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_port (
    .sel_i   (sel_q),
    .stb_en_i(st_q == ST_STB),
    .cnt_i   (cnt_i),
    .strobe_o(strobe_o),
    .cnt_o   (cnt_sel)
  );

  // zero counts are dropped without a word
  assign ser_load = (st_q == ST_CAP) && (cnt_sel != '0);

  sro_word_ser #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ser_load),
    .addr_i (sel_q),
    .cnt_i  (cnt_sel),
    .sdata_o(sdata_o),
    .frame_o(frame_o),
    .done_o (ser_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (enc_any) st_d = ST_STB;
      ST_STB:  st_d = ST_CAP;
      ST_CAP:  st_d = ser_load ? ST_SEND : ST_IDLE;
      ST_SEND: if (ser_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && enc_any) sel_q <= enc_addr;
    end
  end

  assign hit_or_o = enc_any;
endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
  parameter int N_PIX = 256,
  parameter int CNT_W = 5,
  localparam int WORD_W = 1 + $clog2(N_PIX) + CNT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_PIX-1:0] nz_i,
  input logic [N_PIX-1:0] strobe_o,
  input logic             sdata_o,
  input logic             frame_o,
  input logic             hit_or_o
);
  logic [7:0] flen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flen_q <= '0;
    else if (frame_o) flen_q <= flen_q + 1'b1;
    else              flen_q <= '0;
  end

  assert_strobe_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));
  assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strobe_o) |=> !(|strobe_o));
  assert_strobe_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strobe_o) |-> (|(strobe_o & nz_i)));
  assert_start_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> sdata_o);
  assert_frame_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (flen_q < 8'(WORD_W)));
  assert_frame_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_o) |-> (flen_q == 8'(WORD_W)));
  assert_no_strobe_in_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !(|strobe_o));
  assert_strobe_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strobe_o) |-> hit_or_o);
  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_o |-> !sdata_o);
endmodule

bind sro_channel sro_checker #(.N_PIX(N_PIX), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .nz_i    (nz_i),
  .strobe_o(strobe_o),
  .sdata_o (sdata_o),
  .frame_o (frame_o),
  .hit_or_o(hit_or_o)
);

// File: tb/tb_sro_channel.sv
module tb_sro_channel;
  localparam int N     = 256;
  localparam int CW    = 5;
  localparam int QD    = 16;
  localparam int CLK_P = 10;

  logic            clk, rst_n;
  logic [N-1:0]    nz, strobe;
  logic [N*CW-1:0] cnt_vec;
  logic            sdata, frame, hit_or;

  int checks = 0, errors = 0;

  // pixel model: queue of counts per pixel, popped on strobe
  int         qv [N][QD];
  int         qn [N];
  int         qh [N];
  logic [CW-1:0] pcnt [N];

  // per-scenario load, used for expected values
  int sv [N][QD];
  int sn [N];

  int rx_a[$], rx_c[$];
  int stb_total = 0;

  sro_channel #(.N_PIX(N), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .nz_i(nz), .cnt_i(cnt_vec),
    .strobe_o(strobe), .sdata_o(sdata), .frame_o(frame), .hit_or_o(hit_or)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      nz[p] = (qh[p] < qn[p]);
      cnt_vec[p*CW +: CW] = pcnt[p];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin
        qh[p]   <= 0;
        pcnt[p] <= '0;
      end
    end else begin
      for (int p = 0; p < N; p++) begin
        if (strobe[p]) begin
          pcnt[p] <= (qh[p] < qn[p]) ? CW'(qv[p][qh[p]]) : '0;
          qh[p]   <= qh[p] + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // word collector and frame monitor
  logic [13:0] wbits;
  int flen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (|strobe) stb_total++;
      if (frame && (|strobe)) chk(0, "R7", "strobe during frame", 1, 0);
      if (!frame && sdata) chk(0, "R10", "sdata outside frame", 1, 0);
      if (frame) begin
        wbits = {wbits[12:0], sdata};
        flen++;
      end else if (flen > 0) begin
        chk(flen == 14, "R6", "frame length", flen, 14);
        chk(wbits[13] == 1'b1, "R5", "start bit", int'(wbits[13]), 1);
        rx_a.push_back(int'(wbits[12:5]));
        rx_c.push_back(int'(wbits[4:0]));
        flen = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic clear_scn();
    for (int p = 0; p < N; p++) sn[p] = 0;
  endtask

  task automatic add(input int p, input int v);
    sv[p][sn[p]] = v;
    sn[p]++;
  endtask

  // commit scenario to the pixel model and check the resulting stream
  task automatic run_scn(input string name);
    int ea[$], ec[$];
    int h[N];
    int base, sbase, nstb, best, quiet, cyc;
    nstb = 0;
    for (int p = 0; p < N; p++) begin
      h[p] = 0;
      nstb += sn[p];
    end
    forever begin
      best = -1;
      for (int p = 0; p < N; p++) if (h[p] < sn[p]) best = p;
      if (best < 0) break;
      if (sv[best][h[best]] != 0) begin
        ea.push_back(best);
        ec.push_back(sv[best][h[best]]);
      end
      h[best]++;
    end
    base  = rx_a.size();
    sbase = stb_total;
    @(negedge clk);
    for (int p = 0; p < N; p++)
      for (int k = 0; k < sn[p]; k++) begin
        qv[p][qn[p]] = sv[p][k];
        qn[p]++;
      end
    #1;
    chk(hit_or == (nstb > 0), "R9", {name, " hit_or after load"}, int'(hit_or), int'(nstb > 0));
    quiet = 0;
    cyc = 0;
    while (quiet < 8 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (!frame && !(|strobe) && !hit_or) quiet++;
      else quiet = 0;
    end
    chk(cyc < 5000, "R4", {name, " drain"}, cyc, 0);
    chk(!hit_or, "R9", {name, " hit_or after drain"}, int'(hit_or), 0);
    chk(stb_total - sbase == nstb, "R8", {name, " strobe count"}, stb_total - sbase, nstb);
    chk(rx_a.size() - base == ea.size(), "R8", {name, " word count"}, rx_a.size() - base, ea.size());
    for (int i = 0; i < ea.size() && base + i < rx_a.size(); i++) begin
      chk(rx_a[base+i] == ea[i], "R2", {name, " word address"}, rx_a[base+i], ea[i]);
      chk(rx_c[base+i] == ec[i], "R5", {name, " word count field"}, rx_c[base+i], ec[i]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int p = 0; p < N; p++) qn[p] = 0;
    repeat (3) @(negedge clk);
    chk(strobe == '0, "R1", "strobe in reset", int'(|strobe), 0);
    chk(!frame, "R1", "frame in reset", int'(frame), 0);
    chk(!sdata, "R1", "sdata in reset", int'(sdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!frame && strobe == '0, "R1", "idle after reset", int'(frame), 0);
    chk(!hit_or, "R9", "hit_or empty", int'(hit_or), 0);
  endtask

  task automatic t_extremes();   // R2 R5: addresses 0 and 255, full count
    clear_scn();
    add(0, 1);
    add(255, 31);
    run_scn("extremes");
  endtask

  task automatic t_restrobe();   // R4: same pixel served repeatedly
    clear_scn();
    add(100, 3);
    add(100, 7);
    add(100, 12);
    add(200, 1);
    add(50, 9);
    run_scn("restrobe");
  endtask

  task automatic t_zero();       // R8: zero counts suppressed
    clear_scn();
    add(20, 0);
    add(10, 0);
    add(10, 5);
    add(5, 0);
    add(5, 0);
    add(5, 18);
    run_scn("zero");
  endtask

  task automatic t_scatter();    // R2: many pixels, mixed counts
    clear_scn();
    for (int i = 0; i < 24; i++) begin
      add((i * 37 + 11) % N, (i * 7) % 32);
      if (i % 5 == 0) add((i * 37 + 11) % N, 21);
    end
    run_scn("scatter");
  endtask

  task automatic t_dense();      // R2 R4: adjacent block, alternating patterns
    clear_scn();
    for (int p = 120; p < 136; p++) begin
      add(p, (p % 2) ? 10 : 21);
      add(p, p % 3);
    end
    run_scn("dense");
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_extremes();
    t_restrobe();
    t_zero();
    t_scatter();
    t_dense();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule